// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a single-bus processor, built as a small microcode engine rather than a hardwired state machine. A 10-bit microprogram counter addresses an on-chip control store. Each stored word drives the datapath strobes for one step and also chooses the next microaddress. That choice can be the next sequential word, the routine start for the current opcode, a fixed entry address for reset or exception, or the word's own branch target. The branch target is taken only when the word's branch condition holds.

Control fields are stored in vertical form, with one small code per group of mutually exclusive strobes. Decoders expand each code into one-hot strobes at the outputs. The datapath supplies two status bits: a branch-condition flag and a "count is zero" flag. It also supplies a two-bit case selector for multiway branches and a memory-done flag that releases a memory wait step. The control store holds a fetch routine, an add routine, a routine that tests every condition, and a jump to the external address.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low, `upc_o` is 0; this takes effect at once, without waiting for a clock edge. The word at address 0 jumps unconditionally to 100.
- R2: Fetch runs from 100 to 101 to 102. The word at 102 takes the opcode lookup: opcode 1 goes to 200, opcode 2 to 300, opcode 3 to 390, and any other opcode to 400.
- R3: A control-store word is 31 bits. From the MSB down its fields are: next-address select [30:29], condition [28:26], end [25], out-gate [24:22], in-gate [21:19], misc [18:16], register select [15:14], ALU [13:10] and branch target [9:0]. The next-address select codes are 00 increment, 01 opcode lookup, 10 external address, 11 branch target.
- R4: The condition codes are 000 always, 001 if CON, 010 if not CON, 011 if zero, 100 if non-zero and 101 never. When the condition is false, or the select is 00, the next address is the counter plus one. The test routine at 300 to 305 uses these conditions: 300 goes to 310 if CON, 301 to 320 if zero, 302 to 330 if non-zero, 303 to 340 if not CON, and 304 never branches.
- R5: Condition code 110 is an always-taken multiway branch. It ORs `case_i` into bits 3 and 2 of the branch target, so word 305 (target 368) reaches 368, 372, 376 or 380 in one clock.
- R6: When `exc_i` is high at a clock edge, the next address is 400. This overrides every other choice, including a wait hold. Reset overrides exception.
- R7: While the current word's misc code is 001 (Wait) and `mem_done_i` is low, the counter holds its value.
- R8: `out_o[k]` is high exactly when the out-gate code is k (k = 0..6), and code 7 gives no strobe. `in_o[k]` is high exactly when the in-gate code is k (k = 0..5), and codes 6 and 7 give no strobe.
- R9: `misc_o[k]` follows misc code k (k = 0..6), and code 7 gives no strobe. `reg_o[k]` follows register-select code k (k = 0..2), and code 3 gives no strobe. `alu_o` is the one-hot decode of all 16 ALU codes.
- R10: Word 100 gives out code 0, in code 0, misc 5 and ALU 3. Word 201 gives out 3, in none, misc 5, register 2 and ALU 0. Word 202 gives out 1, in 4, register 0 and end high, then jumps to 100. Words not listed in these requirements give no gate, misc or register strobe, give ALU code 0, and jump to 100.
- R11: Select 10 loads the external address, which is 0 when no exception is present. Word 390 uses it, then 0 leads to 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_i | input | 1 | Synchronized exception request |
| opcode_i | input | 5 | Macro-instruction opcode for dispatch |
| con_i | input | 1 | Branch-condition flag from datapath |
| nzero_i | input | 1 | Count-is-zero flag from datapath |
| case_i | input | 2 | Multiway case selector |
| mem_done_i | input | 1 | Memory completion, releases a Wait step |
| upc_o | output | 10 | Current microaddress |
| out_o | output | 7 | One-hot bus-drive strobes |
| in_o | output | 6 | One-hot register-load strobes |
| misc_o | output | 7 | One-hot miscellaneous strobes |
| reg_o | output | 3 | One-hot register-field select |
| alu_o | output | 16 | One-hot ALU function |
| end_o | output | 1 | Last step of a macro-instruction |

## Verification
The assertions assume that `exc_i`, `con_i`, `nzero_i`, `case_i`, `mem_done_i` and `opcode_i` change only between clock edges. They assume that `rst_n` is released away from an edge. They also assume that the opcode is valid in the cycle the counter sits at 102. The stimulus drives every input on the falling edge and keeps exceptions rare, so that whole routines run between them. It holds `mem_done_i` low in random runs to build up wait stretches. Directed runs walk each condition outcome and each multiway case, and check an exception raised during a held wait.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int UA_W    = 10;
  localparam int MUX_W   = 2;
  localparam int BRC_W   = 3;
  localparam int GATE_W  = 3;
  localparam int MISC_W  = 3;
  localparam int RSEL_W  = 2;
  localparam int ALU_W   = 4;
  localparam int OUT_N   = 7;
  localparam int IN_N    = 6;
  localparam int MISC_N  = 7;
  localparam int RSEL_N  = 3;
  localparam int ALU_N   = 1 << ALU_W;
  localparam int MW_LSB  = 2;

  localparam logic [MUX_W-1:0] MX_INC = 2'd0, MX_LOOKUP = 2'd1, MX_EXT = 2'd2, MX_BRANCH = 2'd3;

  localparam logic [BRC_W-1:0] BR_ALWAYS = 3'd0, BR_CON = 3'd1, BR_NCON = 3'd2, BR_ZERO = 3'd3,
                               BR_NZERO = 3'd4, BR_NEVER = 3'd5, BR_MULTI = 3'd6;

  localparam logic [GATE_W-1:0] OG_PC = 3'd0, OG_C = 3'd1, OG_MD = 3'd2, OG_R = 3'd3, OG_NONE = 3'd7;
  localparam logic [GATE_W-1:0] IG_MA = 3'd0, IG_PC = 3'd1, IG_IR = 3'd2, IG_A = 3'd3, IG_R = 3'd4,
                                IG_NONE = 3'd6;
  localparam logic [MISC_W-1:0] MS_WAIT = 3'd1, MS_CIN = 3'd5, MS_NONE = 3'd7;
  localparam logic [RSEL_W-1:0] RS_A = 2'd0, RS_B = 2'd1, RS_C = 2'd2, RS_NONE = 2'd3;
  localparam logic [ALU_W-1:0]  AL_ADD = 4'd0, AL_INC4 = 4'd3;

  localparam logic [UA_W-1:0] UA_RESET = 10'd0,   UA_FETCH = 10'd100, UA_DISPATCH = 10'd102,
                              UA_ADD   = 10'd200, UA_TEST  = 10'd300, UA_CON_T    = 10'd310,
                              UA_EXTJ  = 10'd390, UA_EXC   = 10'd400;

  typedef struct packed {
    logic [MUX_W-1:0]  mux;
    logic [BRC_W-1:0]  brc;
    logic              fin;
    logic [GATE_W-1:0] og;
    logic [GATE_W-1:0] ig;
    logic [MISC_W-1:0] misc;
    logic [RSEL_W-1:0] rsel;
    logic [ALU_W-1:0]  alu;
    logic [UA_W-1:0]   baddr;
  } uword_t;

  function automatic uword_t uw(input logic [MUX_W-1:0] mux, input logic [BRC_W-1:0] brc,
                                input logic fin, input logic [GATE_W-1:0] og,
                                input logic [GATE_W-1:0] ig, input logic [MISC_W-1:0] misc,
                                input logic [RSEL_W-1:0] rsel, input logic [ALU_W-1:0] alu,
                                input logic [UA_W-1:0] baddr);
    uword_t w;
    w.mux = mux; w.brc = brc; w.fin = fin; w.og = og; w.ig = ig;
    w.misc = misc; w.rsel = rsel; w.alu = alu; w.baddr = baddr;
    return w;
  endfunction
endpackage

// File: rtl/ucode_store.sv
module ucode_store
  import ucode_pkg::*;
#(
  parameter int OPC_W    = 5,
  parameter int OPC_ADD  = 1,
  parameter int OPC_TEST = 2,
  parameter int OPC_EXTJ = 3
) (
  input  logic [UA_W-1:0]  addr,
  input  logic [OPC_W-1:0] opcode,
  output uword_t           word,
  output logic [UA_W-1:0]  start_addr
);
  // Control store: unlisted addresses return to fetch with all strobes idle.
  always_comb begin
    word = uw(MX_BRANCH, BR_ALWAYS, 1'b0, OG_NONE, IG_NONE, MS_NONE, RS_NONE, AL_ADD, UA_FETCH);
    case (addr)
      10'd100: word = uw(MX_INC, BR_NEVER, 1'b0, OG_PC, IG_MA, MS_CIN, RS_NONE, AL_INC4, UA_RESET);
      10'd101: word = uw(MX_INC, BR_NEVER, 1'b0, OG_C, IG_PC, MS_WAIT, RS_NONE, AL_ADD, UA_RESET);
      10'd102: word = uw(MX_LOOKUP, BR_ALWAYS, 1'b0, OG_MD, IG_IR, MS_NONE, RS_NONE, AL_ADD, UA_RESET);
      10'd200: word = uw(MX_INC, BR_NEVER, 1'b0, OG_R, IG_A, MS_NONE, RS_B, AL_ADD, UA_RESET);
      10'd201: word = uw(MX_INC, BR_NEVER, 1'b0, OG_R, IG_NONE, MS_CIN, RS_C, AL_ADD, UA_RESET);
      10'd202: word = uw(MX_BRANCH, BR_ALWAYS, 1'b1, OG_C, IG_R, MS_NONE, RS_A, AL_ADD, UA_FETCH);
      10'd300: word = uw(MX_BRANCH, BR_CON, 1'b0, OG_NONE, IG_NONE, MS_NONE, RS_NONE, AL_ADD, 10'd310);
      10'd301: word = uw(MX_BRANCH, BR_ZERO, 1'b0, OG_NONE, IG_NONE, MS_NONE, RS_NONE, AL_ADD, 10'd320);
      10'd302: word = uw(MX_BRANCH, BR_NZERO, 1'b0, OG_NONE, IG_NONE, MS_NONE, RS_NONE, AL_ADD, 10'd330);
      10'd303: word = uw(MX_BRANCH, BR_NCON, 1'b0, OG_NONE, IG_NONE, MS_NONE, RS_NONE, AL_ADD, 10'd340);
      10'd304: word = uw(MX_BRANCH, BR_NEVER, 1'b0, OG_NONE, IG_NONE, MS_NONE, RS_NONE, AL_ADD, 10'd350);
      10'd305: word = uw(MX_BRANCH, BR_MULTI, 1'b0, OG_NONE, IG_NONE, MS_NONE, RS_NONE, AL_ADD, 10'd368);
      10'd390: word = uw(MX_EXT, BR_ALWAYS, 1'b0, OG_NONE, IG_NONE, MS_NONE, RS_NONE, AL_ADD, UA_RESET);
      default: ;
    endcase
  end

  // Opcode to routine start lookup.
  always_comb begin
    if (opcode == OPC_W'(OPC_ADD))       start_addr = UA_ADD;
    else if (opcode == OPC_W'(OPC_TEST)) start_addr = UA_TEST;
    else if (opcode == OPC_W'(OPC_EXTJ)) start_addr = UA_EXTJ;
    else                                 start_addr = UA_EXC;
  end
endmodule

// File: rtl/ucode_next.sv
module ucode_next
  import ucode_pkg::*;
#(
  parameter int CASE_W = 2
) (
  input  logic [UA_W-1:0]   upc,
  input  logic [MUX_W-1:0]  mux,
  input  logic [BRC_W-1:0]  brc,
  input  logic [MISC_W-1:0] misc,
  input  logic [UA_W-1:0]   baddr,
  input  logic [UA_W-1:0]   start_addr,
  input  logic              con,
  input  logic              nzero,
  input  logic [CASE_W-1:0] case_sel,
  input  logic              exc,
  input  logic              mem_done,
  output logic [UA_W-1:0]   upc_d,
  output logic              upc_en
);
  logic [UA_W-1:0] inc_addr;
  logic [UA_W-1:0] ext_addr;
  logic [UA_W-1:0] target;
  logic            taken;
  logic            stall;

  always_comb begin
    inc_addr = upc + UA_W'(1);
    ext_addr = exc ? UA_EXC : UA_RESET;
    stall    = (misc == MS_WAIT) && !mem_done;

    case (brc)
      BR_ALWAYS: taken = 1'b1;
      BR_CON:    taken = con;
      BR_NCON:   taken = !con;
      BR_ZERO:   taken = nzero;
      BR_NZERO:  taken = !nzero;
      BR_MULTI:  taken = 1'b1;
      default:   taken = 1'b0;
    endcase

    case (mux)
      MX_INC:    target = inc_addr;
      MX_LOOKUP: target = start_addr;
      MX_EXT:    target = ext_addr;
      default:   target = (brc == BR_MULTI) ? (baddr | (UA_W'(case_sel) << MW_LSB)) : baddr;
    endcase

    upc_en = exc || !stall;
    if (exc)                          upc_d = UA_EXC;
    else if ((mux != MX_INC) && taken) upc_d = target;
    else                              upc_d = inc_addr;
  end
endmodule

// File: rtl/onehot_dec.sv
module onehot_dec #(
  parameter int CODE_W = 3,
  parameter int N      = 7
) (
  input  logic [CODE_W-1:0] code,
  output logic [N-1:0]      hot
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hot[i] = (code == CODE_W'(i));
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_pkg::*;
#(
  parameter int OPC_W  = 5,
  parameter int CASE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              con_i,
  input  logic              nzero_i,
  input  logic [CASE_W-1:0] case_i,
  input  logic              mem_done_i,
  output logic [UA_W-1:0]   upc_o,
  output logic [OUT_N-1:0]  out_o,
  output logic [IN_N-1:0]   in_o,
  output logic [MISC_N-1:0] misc_o,
  output logic [RSEL_N-1:0] reg_o,
  output logic [ALU_N-1:0]  alu_o,
  output logic              end_o
);
  logic [UA_W-1:0] upc_q;
  logic [UA_W-1:0] upc_d;
  logic            upc_en;
  logic [UA_W-1:0] start_addr;
  uword_t          word;

  ucode_store #(.OPC_W(OPC_W)) u_store (
    .addr(upc_q), .opcode(opcode_i), .word(word), .start_addr(start_addr)
  );

  ucode_next #(.CASE_W(CASE_W)) u_next (
    .upc(upc_q), .mux(word.mux), .brc(word.brc), .misc(word.misc), .baddr(word.baddr),
    .start_addr(start_addr), .con(con_i), .nzero(nzero_i), .case_sel(case_i),
    .exc(exc_i), .mem_done(mem_done_i), .upc_d(upc_d), .upc_en(upc_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upc_q <= UA_RESET;
    else if (upc_en) upc_q <= upc_d;
  end

  onehot_dec #(.CODE_W(GATE_W), .N(OUT_N))  u_dec_out  (.code(word.og),   .hot(out_o));
  onehot_dec #(.CODE_W(GATE_W), .N(IN_N))   u_dec_in   (.code(word.ig),   .hot(in_o));
  onehot_dec #(.CODE_W(MISC_W), .N(MISC_N)) u_dec_misc (.code(word.misc), .hot(misc_o));
  onehot_dec #(.CODE_W(RSEL_W), .N(RSEL_N)) u_dec_reg  (.code(word.rsel), .hot(reg_o));
  onehot_dec #(.CODE_W(ALU_W),  .N(ALU_N))  u_dec_alu  (.code(word.alu),  .hot(alu_o));

  assign upc_o = upc_q;
  assign end_o = word.fin;
endmodule

// File: rtl/ucode_sequencer_chk.sv
module ucode_sequencer_chk
  import ucode_pkg::*;
#(
  parameter int OPC_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_i,
  input logic [OPC_W-1:0]  opcode_i,
  input logic              con_i,
  input logic              mem_done_i,
  input logic [UA_W-1:0]   upc_o,
  input logic [OUT_N-1:0]  out_o,
  input logic [IN_N-1:0]   in_o,
  input logic [MISC_N-1:0] misc_o,
  input logic [RSEL_N-1:0] reg_o,
  input logic [ALU_N-1:0]  alu_o,
  input logic              end_o
);
  assert_exc_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> (upc_o == UA_EXC));

  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (misc_o[MS_WAIT] && !mem_done_i && !exc_i) |=> $stable(upc_o));

  assert_gate_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_o) && $onehot0(in_o));

  assert_field_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(misc_o) && $onehot0(reg_o) && ($countones(alu_o) == 1));

  assert_dispatch_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_o == UA_DISPATCH && !exc_i && opcode_i == OPC_W'(1)) |=> (upc_o == UA_ADD));

  assert_con_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_o == UA_TEST && con_i && !exc_i) |=> (upc_o == UA_CON_T));

  assert_end_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (end_o && !exc_i) |=> (upc_o == UA_FETCH));
endmodule

bind ucode_sequencer ucode_sequencer_chk #(.OPC_W(OPC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_i(exc_i), .opcode_i(opcode_i), .con_i(con_i),
  .mem_done_i(mem_done_i), .upc_o(upc_o), .out_o(out_o), .in_o(in_o), .misc_o(misc_o),
  .reg_o(reg_o), .alu_o(alu_o), .end_o(end_o)
);

// File: tb/ucode_sequencer_bench.sv
module ucode_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_i;
  logic [4:0]  opcode_i;
  logic        con_i;
  logic        nzero_i;
  logic [1:0]  case_i;
  logic        mem_done_i;
  logic [9:0]  upc_o;
  logic [6:0]  out_o;
  logic [5:0]  in_o;
  logic [6:0]  misc_o;
  logic [2:0]  reg_o;
  logic [15:0] alu_o;
  logic        end_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [9:0] m_upc;

  always #5 clk = ~clk;

  ucode_sequencer u_ucode_sequencer (
    .clk(clk), .rst_n(rst_n), .exc_i(exc_i), .opcode_i(opcode_i), .con_i(con_i),
    .nzero_i(nzero_i), .case_i(case_i), .mem_done_i(mem_done_i), .upc_o(upc_o),
    .out_o(out_o), .in_o(in_o), .misc_o(misc_o), .reg_o(reg_o), .alu_o(alu_o), .end_o(end_o)
  );

  // Word layout per R3: {sel,cond,end,out,in,misc,reg,alu,target}
  function automatic logic [30:0] bw(input logic [1:0] m, input logic [2:0] b, input logic e,
                                     input logic [2:0] o, input logic [2:0] i, input logic [2:0] s,
                                     input logic [1:0] r, input logic [3:0] a, input logic [9:0] t);
    return {m, b, e, o, i, s, r, a, t};
  endfunction

  // Expected store contents from R1, R2, R4, R5, R10, R11
  function automatic logic [30:0] ref_word(input logic [9:0] ad);
    case (ad)
      10'd100: return bw(2'd0, 3'd5, 1'b0, 3'd0, 3'd0, 3'd5, 2'd3, 4'd3, 10'd0);
      10'd101: return bw(2'd0, 3'd5, 1'b0, 3'd1, 3'd1, 3'd1, 2'd3, 4'd0, 10'd0);
      10'd102: return bw(2'd1, 3'd0, 1'b0, 3'd2, 3'd2, 3'd7, 2'd3, 4'd0, 10'd0);
      10'd200: return bw(2'd0, 3'd5, 1'b0, 3'd3, 3'd3, 3'd7, 2'd1, 4'd0, 10'd0);
      10'd201: return bw(2'd0, 3'd5, 1'b0, 3'd3, 3'd6, 3'd5, 2'd2, 4'd0, 10'd0);
      10'd202: return bw(2'd3, 3'd0, 1'b1, 3'd1, 3'd4, 3'd7, 2'd0, 4'd0, 10'd100);
      10'd300: return bw(2'd3, 3'd1, 1'b0, 3'd7, 3'd6, 3'd7, 2'd3, 4'd0, 10'd310);
      10'd301: return bw(2'd3, 3'd3, 1'b0, 3'd7, 3'd6, 3'd7, 2'd3, 4'd0, 10'd320);
      10'd302: return bw(2'd3, 3'd4, 1'b0, 3'd7, 3'd6, 3'd7, 2'd3, 4'd0, 10'd330);
      10'd303: return bw(2'd3, 3'd2, 1'b0, 3'd7, 3'd6, 3'd7, 2'd3, 4'd0, 10'd340);
      10'd304: return bw(2'd3, 3'd5, 1'b0, 3'd7, 3'd6, 3'd7, 2'd3, 4'd0, 10'd350);
      10'd305: return bw(2'd3, 3'd6, 1'b0, 3'd7, 3'd6, 3'd7, 2'd3, 4'd0, 10'd368);
      10'd390: return bw(2'd2, 3'd0, 1'b0, 3'd7, 3'd6, 3'd7, 2'd3, 4'd0, 10'd0);
      default: return bw(2'd3, 3'd0, 1'b0, 3'd7, 3'd6, 3'd7, 2'd3, 4'd0, 10'd100);
    endcase
  endfunction

  function automatic logic [9:0] ref_next(input logic [9:0] pc, input logic [4:0] opc,
                                          input logic con, input logic nz, input logic [1:0] cs,
                                          input logic done, input logic exc);
    logic [30:0] w;
    logic        tk;
    logic [9:0]  tg;
    w = ref_word(pc);
    if (exc) return 10'd400;
    if (w[18:16] == 3'd1 && !done) return pc;
    case (w[28:26])
      3'd0, 3'd6: tk = 1'b1;
      3'd1: tk = con;
      3'd2: tk = !con;
      3'd3: tk = nz;
      3'd4: tk = !nz;
      default: tk = 1'b0;
    endcase
    case (w[30:29])
      2'd1: tg = (opc == 5'd1) ? 10'd200 : (opc == 5'd2) ? 10'd300 : (opc == 5'd3) ? 10'd390 : 10'd400;
      2'd2: tg = 10'd0;
      default: tg = (w[28:26] == 3'd6) ? (w[9:0] | {6'd0, cs, 2'd0}) : w[9:0];
    endcase
    if (w[30:29] != 2'd0 && tk) return tg;
    return pc + 10'd1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_strobes();
    logic [30:0] w;
    w = ref_word(m_upc);
    chk("R8 out strobes", int'(out_o), (w[24:22] == 3'd7) ? 0 : (1 << w[24:22]));
    chk("R8 in strobes", int'(in_o), (w[21:19] >= 3'd6) ? 0 : (1 << w[21:19]));
    chk("R9 misc strobes", int'(misc_o), (w[18:16] == 3'd7) ? 0 : (1 << w[18:16]));
    chk("R9 reg strobes", int'(reg_o), (w[15:14] == 2'd3) ? 0 : (1 << w[15:14]));
    chk("R9 alu strobes", int'(alu_o), 1 << w[13:10]);
    chk("R10 end flag", int'(end_o), int'(w[25]));
  endtask

  task automatic step(input string tag, input logic [4:0] opc, input logic con, input logic nz,
                      input logic [1:0] cs, input logic done, input logic exc);
    logic [9:0] exp;
    opcode_i = opc; con_i = con; nzero_i = nz; case_i = cs; mem_done_i = done; exc_i = exc;
    exp = ref_next(m_upc, opc, con, nz, cs, done, exc);
    @(posedge clk);
    @(negedge clk);
    m_upc = exp;
    chk(tag, int'(upc_o), int'(exp));
    chk_strobes();
  endtask

  task automatic go(input string tag, input logic con, input logic nz);
    step(tag, 5'd0, con, nz, 2'd0, 1'b1, 1'b0);
  endtask

  task automatic fetch(input logic [4:0] opc);
    step("R2 fetch 100->101", opc, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
    step("R2 fetch 101->102", opc, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
    step("R2 dispatch", opc, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=150000 expected=finish earlier");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b1; exc_i = 1'b0; opcode_i = '0; con_i = 1'b0; nzero_i = 1'b0;
    case_i = '0; mem_done_i = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    m_upc = 10'd0;
    chk("R1 reset address", int'(upc_o), 0);
    chk_strobes();
    rst_n = 1'b1;

    go("R1 reset word to fetch", 1'b0, 1'b0);
    chk("R1 at fetch", int'(upc_o), 100);
    chk("R10 word100 out", int'(out_o), 1);
    chk("R10 word100 alu inc4", int'(alu_o), 8);
    go("R2 100->101", 1'b0, 1'b0);
    step("R7 wait hold", 5'd1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    chk("R7 held at 101", int'(upc_o), 101);
    step("R7 wait hold 2", 5'd1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    step("R7 wait release", 5'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
    step("R2 opcode 1", 5'd1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
    chk("R2 add entry", int'(upc_o), 200);
    go("R10 200->201", 1'b0, 1'b0);
    chk("R10 word201 reg", int'(reg_o), 4);
    go("R10 201->202", 1'b0, 1'b0);
    chk("R10 word202 end", int'(end_o), 1);
    go("R10 return", 1'b0, 1'b0);
    chk("R10 back at fetch", int'(upc_o), 100);

    fetch(5'd2);
    go("R4 if CON taken", 1'b1, 1'b0);
    chk("R4 CON target", int'(upc_o), 310);
    go("R10 default word", 1'b0, 1'b0);

    fetch(5'd2);
    go("R4 CON false", 1'b0, 1'b0);
    go("R4 zero taken", 1'b0, 1'b1);
    chk("R4 zero target", int'(upc_o), 320);
    go("R10 default word", 1'b0, 1'b0);

    fetch(5'd2);
    go("R4 CON false", 1'b0, 1'b0);
    go("R4 zero false", 1'b0, 1'b0);
    go("R4 nonzero taken", 1'b0, 1'b0);
    chk("R4 nonzero target", int'(upc_o), 330);
    go("R10 default word", 1'b0, 1'b0);

    for (int k = 0; k < 4; k++) begin
      fetch(5'd2);
      go("R4 CON false", 1'b0, 1'b0);
      go("R4 zero false", 1'b0, 1'b0);
      go("R4 nonzero false", 1'b0, 1'b1);
      go("R4 not CON false", 1'b1, 1'b0);
      chk("R4 never branch", int'(upc_o), 304);
      go("R4 never branch", 1'b0, 1'b0);
      step("R5 multiway", 5'd0, 1'b0, 1'b0, 2'(k), 1'b1, 1'b0);
      chk("R5 multiway target", int'(upc_o), 368 + 4 * k);
      go("R10 default word", 1'b0, 1'b0);
    end

    fetch(5'd2);
    go("R4 CON false", 1'b0, 1'b0);
    go("R4 zero false", 1'b0, 1'b0);
    go("R4 nonzero false", 1'b0, 1'b1);
    go("R4 not CON taken", 1'b0, 1'b0);
    chk("R4 not CON target", int'(upc_o), 340);
    go("R10 default word", 1'b0, 1'b0);

    fetch(5'd3);
    go("R11 external address", 1'b0, 1'b0);
    chk("R11 external zero", int'(upc_o), 0);
    go("R1 reset word", 1'b0, 1'b0);

    fetch(5'd9);
    chk("R2 unknown opcode", int'(upc_o), 400);
    go("R10 default word", 1'b0, 1'b0);

    step("R6 exception", 5'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1);
    chk("R6 exception vector", int'(upc_o), 400);
    go("R10 default word", 1'b0, 1'b0);
    go("R2 100->101", 1'b0, 1'b0);
    step("R6 exception over wait", 5'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R6 vector from wait", int'(upc_o), 400);

    exc_i = 1'b1;
    rst_n = 1'b0;
    #1;
    m_upc = 10'd0;
    chk("R1 async reset over exception", int'(upc_o), 0);
    @(negedge clk);
    chk("R1 reset held", int'(upc_o), 0);
    exc_i = 1'b0;
    rst_n = 1'b1;

    for (int n = 0; n < 3000; n++) begin
      step("R4 random sequencing", 5'($urandom % 5), 1'($urandom), 1'($urandom), 2'($urandom),
           ($urandom % 4) != 0, ($urandom % 64) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule